// File: doc/BRIEF.md
# NAND Page-Program and Block-Erase Host Sequencer

This block sits on the host side of an 8-bit multiplexed NAND port and turns one request into a complete, correctly ordered bus transaction. A program request sends the load opcode, a column byte, two row bytes, between 1 and 264 payload bytes fetched by index from a caller-owned buffer, and the confirm opcode. An erase request sends the erase-setup opcode, the two row bytes and the erase confirm. Either way, the sequencer then waits out the device's busy period, writes the status opcode, reads one status byte and reports pass or fail.

Every write-strobe and read-strobe phase lasts a parameterised number of clock cycles, so one netlist fits any clock rate. Programs aimed at the 8-byte spare region are wrapped: a pointer-to-spare opcode goes before them and a pointer-to-main opcode goes after them. A per-page counter refuses further partial programs once the page has been programmed its allowed number of times. A successful erase of the page's block clears that counter. A timeout ends an operation whose ready line never returns. The result stays on the outputs, tagged with the block number of the request, until the next request is accepted.

Top module: `nand_pe_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, the port is idle: nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle, nand_ale and nand_dq_oe are 0, and done is 0.
- R2: A program writes, in this order, 80h with nand_cle=1, then with nand_ale=1 the column byte, the row bits 7:0 and the row bits 15:8 (zero-extended), then byte_count payload bytes with both latch lines 0, taken from buf_data at buf_idx = 0 .. byte_count-1, then 10h with nand_cle=1.
- R3: When use_spare=1 on a program, 50h (nand_cle=1) is written before 80h, and 00h (nand_cle=1) is written after the status read.
- R4: An erase writes 60h (nand_cle=1), then the row bits 7:0 and 15:8 with nand_ale=1 (no column byte), then D0h (nand_cle=1). use_spare is ignored for an erase.
- R5: Every write cycle holds nand_we_n low for exactly WE_LO clocks, then high for at least WE_HI clocks. The byte and the latch lines stay constant from the falling edge until after the rising edge. nand_cle and nand_ale are never both 1. A status read holds nand_re_n low for exactly RE_LO clocks, and nand_we_n and nand_re_n are never low together.
- R6: After the confirm byte, nand_rb is ignored for WB_CYC clocks. The status opcode 70h is written only once nand_rb has been seen high after that window, and it is followed by exactly one read cycle.
- R7: pass is 1 only if the status byte has bit 0 = 0 (operation succeeded) and bit 6 = 1 (ready). Any other status gives done=1 with pass=0.
- R8: If nand_rb is not high within PRG_TMO (program) or ERS_TMO (erase) clocks of the confirm byte, the sequencer ends with done=1, pass=0 and timed_out=1, and writes no status opcode.
- R9: A program to a page that has already been accepted PART_MAX times since the last passing erase of its block is refused: done=1, pass=0, refused=1, and no bus cycle occurs.
- R10: An erase that passes clears the program count of every page in its block (row >> BLK_SHIFT). An erase that fails clears nothing.
- R11: A program with byte_count of 0 or above 264 is refused in the same way as R9.
- R12: done, pass, refused and timed_out hold their values until the next start is accepted. start is accepted only while idle or done, and a start pulse during an operation has no effect.
- R13: fail_blk shows the request's row >> BLK_SHIFT whenever done=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse |
| op_erase | input | 1 | 1 = block erase, 0 = page program |
| use_spare | input | 1 | Program targets the spare region |
| col_addr | input | 8 | Column byte for a program |
| row_addr | input | ROW_W | Page (row) address |
| byte_count | input | 9 | Payload length for a program, 1..264 |
| buf_idx | output | 9 | Index of the payload byte wanted |
| buf_data | input | 8 | Payload byte at buf_idx, same cycle |
| done | output | 1 | Operation finished (held) |
| pass | output | 1 | Operation succeeded (held) |
| refused | output | 1 | Request rejected without bus activity |
| timed_out | output | 1 | Ready line did not return in time |
| fail_blk | output | ROW_W-BLK_SHIFT | Block number of the last request |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch strobe qualifier |
| nand_ale | output | 1 | Address latch strobe qualifier |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Byte driven onto the bus |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_i | input | 8 | Byte read from the bus |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
Programs are issued with payload lengths of 1, 5, 7 and the full 264 bytes, at different columns and rows. Comparing the captured byte stream against the arithmetic payload pattern separates correct index sequencing from off-by-one or truncated transfers. Spare-region programs and erases are compared against their own opcode framing, which shows whether the wrapper opcodes appear and whether the column byte is dropped for erases. The status byte is swept over success, failure and not-ready codes, and the ready line is either delayed past the ignore window or held low forever. Together these distinguish a correct status decode, early status polling and the timeout path. A run of eleven programs to one page, with a failing and then a passing erase in between, separates correct counting, counting past the cap and clearing on the wrong outcome.

// File: rtl/nand_seq_pkg.sv
// Shared opcodes, state encodings and bus request type for the NAND
// program/erase sequencer. Assumes an 8-bit multiplexed device port.
package nand_seq_pkg;

    localparam logic [7:0] OP_PROG_LOAD   = 8'h80;
    localparam logic [7:0] OP_PROG_GO     = 8'h10;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_STATUS      = 8'h70;
    localparam logic [7:0] OP_PTR_MAIN    = 8'h00;
    localparam logic [7:0] OP_PTR_SPARE   = 8'h50;

    localparam int PAGE_BYTES    = 264;
    localparam int STAT_FAIL_BIT = 0;
    localparam int STAT_RDY_BIT  = 6;

    typedef enum logic [3:0] {
        S_IDLE, S_PTR, S_CMD, S_ADDR, S_DATA, S_CONF,
        S_GAP, S_WAIT, S_STCMD, S_STRD, S_RESTORE, S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {BC_IDLE, BC_LOW, BC_HIGH} bus_phase_t;

    typedef struct packed {
        logic       rd;
        logic       cle;
        logic       ale;
        logic [7:0] dat;
    } bus_req_t;

endpackage

// File: rtl/nand_bus_cycle.sv
// Executes one NAND bus cycle (byte write or byte read) with strobe phases
// timed in clock cycles. Assumes the caller pulses go only while ready=1;
// ack marks the final cycle. Read data is captured at the end of the low phase.
module nand_bus_cycle
    import nand_seq_pkg::*;
#(
    parameter int WE_LO = 5,
    parameter int WE_HI = 5,
    parameter int RE_LO = 7,
    parameter int RE_HI = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  bus_req_t   req,
    output logic       ready,
    output logic       ack,
    output logic [7:0] rdat,
    output logic       we_n,
    output logic       re_n,
    output logic       cle,
    output logic       ale,
    output logic [7:0] dq_o,
    output logic       dq_oe,
    input  logic [7:0] dq_i
);
    localparam int MAX_W  = (WE_LO > WE_HI) ? WE_LO : WE_HI;
    localparam int MAX_R  = (RE_LO > RE_HI) ? RE_LO : RE_HI;
    localparam int MAX_C  = (MAX_W > MAX_R) ? MAX_W : MAX_R;
    localparam int CW     = $clog2(MAX_C + 1);

    bus_phase_t    phase;
    logic [CW-1:0] cnt;
    bus_req_t      cur;
    logic [7:0]    rdat_q;
    logic          active;

    // Phase sequencer: idle -> strobe low -> strobe high -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= BC_IDLE;
            cnt    <= '0;
            cur    <= '0;
            rdat_q <= '0;
        end else begin
            case (phase)
                BC_IDLE: if (go) begin
                    cur   <= req;
                    phase <= BC_LOW;
                    cnt   <= req.rd ? CW'(RE_LO - 1) : CW'(WE_LO - 1);
                end
                BC_LOW: if (cnt == '0) begin
                    if (cur.rd) rdat_q <= dq_i;
                    phase <= BC_HIGH;
                    cnt   <= cur.rd ? CW'(RE_HI - 1) : CW'(WE_HI - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                BC_HIGH: if (cnt == '0) begin
                    phase <= BC_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: phase <= BC_IDLE;
            endcase
        end
    end

    // Pin decode from the registered phase and latched request.
    always_comb begin
        active = (phase != BC_IDLE);
        ready  = (phase == BC_IDLE);
        ack    = (phase == BC_HIGH) && (cnt == '0);
        we_n   = !((phase == BC_LOW) && !cur.rd);
        re_n   = !((phase == BC_LOW) && cur.rd);
        cle    = active && cur.cle;
        ale    = active && cur.ale;
        dq_o   = cur.dat;
        dq_oe  = active && !cur.rd;
        rdat   = rdat_q;
    end

    // R5: strobes never overlap.
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    // R5: byte and latch lines frozen while the write strobe is low.
    p_wdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(dq_o) && $stable(cle) && $stable(ale)));
    // R5: byte held across the rising write strobe.
    p_wdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> ($stable(dq_o) && $stable(cle) && $stable(ale)));

endmodule

// File: rtl/nand_page_tally.sv
// Per-page partial-program counters. Assumes one bump per accepted program
// and a wipe of a whole block after a passing erase; wipe wins over bump.
module nand_page_tally #(
    parameter int ROW_W     = 8,
    parameter int BLK_SHIFT = 4,
    parameter int LIMIT     = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ROW_W-1:0]           look_page,
    output logic                       look_full,
    input  logic                       bump,
    input  logic                       wipe,
    input  logic [ROW_W-BLK_SHIFT-1:0] wipe_blk
);
    localparam int PAGES = 1 << ROW_W;
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_all [PAGES];
    logic [CNT_W-1:0] look_cnt;

    for (genvar p = 0; p < PAGES; p++) begin : g_pg
        localparam logic [ROW_W-1:0] PG = ROW_W'(p);
        logic [CNT_W-1:0] c;
        // One counter per page: cleared by a block wipe, raised by a bump.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c <= '0;
            end else if (wipe && (PG[ROW_W-1:BLK_SHIFT] == wipe_blk)) begin
                c <= '0;
            end else if (bump && (look_page == PG)) begin
                c <= c + 1'b1;
            end
        end
        assign cnt_all[p] = c;
    end

    // Count lookup for the requested page.
    always_comb begin
        look_cnt  = cnt_all[look_page];
        look_full = (look_cnt >= CNT_W'(LIMIT));
    end

    // R9: no bump is granted to a full page.
    p_no_bump_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bump |-> !look_full);
    // R9: a count never passes the cap.
    p_count_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        look_cnt <= CNT_W'(LIMIT));

endmodule

// File: rtl/nand_pe_seq.sv
// Host-side page-program / block-erase sequencer for an 8-bit NAND port.
// Assumes buf_data is valid combinationally for buf_idx, PRG_TMO and ERS_TMO
// exceed WB_CYC, and ROW_W is at most 16 (two row address bytes).
module nand_pe_seq
    import nand_seq_pkg::*;
#(
    parameter int ROW_W     = 8,
    parameter int BLK_SHIFT = 4,
    parameter int WE_LO     = 5,
    parameter int WE_HI     = 5,
    parameter int RE_LO     = 7,
    parameter int RE_HI     = 3,
    parameter int WB_CYC    = 32,
    parameter int PRG_TMO   = 187500,
    parameter int ERS_TMO   = 1250000,
    parameter int PART_MAX  = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       op_erase,
    input  logic                       use_spare,
    input  logic [7:0]                 col_addr,
    input  logic [ROW_W-1:0]           row_addr,
    input  logic [8:0]                 byte_count,
    output logic [8:0]                 buf_idx,
    input  logic [7:0]                 buf_data,
    output logic                       done,
    output logic                       pass,
    output logic                       refused,
    output logic                       timed_out,
    output logic [ROW_W-BLK_SHIFT-1:0] fail_blk,
    output logic                       nand_ce_n,
    output logic                       nand_cle,
    output logic                       nand_ale,
    output logic                       nand_we_n,
    output logic                       nand_re_n,
    output logic [7:0]                 nand_dq_o,
    output logic                       nand_dq_oe,
    input  logic [7:0]                 nand_dq_i,
    input  logic                       nand_rb
);
    localparam int TMO_MAX = (PRG_TMO > ERS_TMO) ? PRG_TMO : ERS_TMO;
    localparam int TMO_W   = $clog2(TMO_MAX + 1);

    seq_state_t       st;
    logic             is_erase, is_spare, ok_q;
    logic [7:0]       col_q;
    logic [ROW_W-1:0] row_q;
    logic [8:0]       len_q, idx;
    logic [TMO_W-1:0] tmo_cnt, tmo_lim;
    logic [15:0]      row_ext;
    logic [1:0]       addr_sel;

    bus_req_t   breq;
    logic       go, eng_ready, eng_ack, issuing;
    logic [7:0] eng_rdat;

    logic accept, len_ok, refuse, tally_full, bump, wipe, ok_now;

    // Request admission and derived selectors.
    always_comb begin
        accept   = start && ((st == S_IDLE) || (st == S_DONE));
        len_ok   = (byte_count != 9'd0) && (byte_count <= 9'(PAGE_BYTES));
        refuse   = !op_erase && (!len_ok || tally_full);
        bump     = accept && !op_erase && !refuse;
        ok_now   = !eng_rdat[STAT_FAIL_BIT] && eng_rdat[STAT_RDY_BIT];
        wipe     = (st == S_STRD) && eng_ack && is_erase && ok_now;
        row_ext  = 16'(row_q);
        addr_sel = is_erase ? (idx[1:0] + 2'd1) : idx[1:0];
        tmo_lim  = is_erase ? TMO_W'(ERS_TMO - 1) : TMO_W'(PRG_TMO - 1);
        buf_idx  = idx;
    end

    // Bus request selection for the current step.
    always_comb begin
        breq    = '0;
        issuing = 1'b1;
        case (st)
            S_PTR:     begin breq.cle = 1'b1; breq.dat = OP_PTR_SPARE; end
            S_CMD:     begin breq.cle = 1'b1; breq.dat = is_erase ? OP_ERASE_SETUP : OP_PROG_LOAD; end
            S_ADDR: begin
                breq.ale = 1'b1;
                case (addr_sel)
                    2'd0:    breq.dat = col_q;
                    2'd1:    breq.dat = row_ext[7:0];
                    default: breq.dat = row_ext[15:8];
                endcase
            end
            S_DATA:    breq.dat = buf_data;
            S_CONF:    begin breq.cle = 1'b1; breq.dat = is_erase ? OP_ERASE_GO : OP_PROG_GO; end
            S_STCMD:   begin breq.cle = 1'b1; breq.dat = OP_STATUS; end
            S_STRD:    breq.rd = 1'b1;
            S_RESTORE: begin breq.cle = 1'b1; breq.dat = OP_PTR_MAIN; end
            default:   issuing = 1'b0;
        endcase
        go = issuing && eng_ready;
    end

    // Operation sequencer with busy wait, timeout and held result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            is_erase  <= 1'b0;
            is_spare  <= 1'b0;
            ok_q      <= 1'b0;
            col_q     <= '0;
            row_q     <= '0;
            len_q     <= '0;
            idx       <= '0;
            tmo_cnt   <= '0;
            done      <= 1'b0;
            pass      <= 1'b0;
            refused   <= 1'b0;
            timed_out <= 1'b0;
            fail_blk  <= '0;
        end else if (accept) begin
            is_erase  <= op_erase;
            is_spare  <= use_spare && !op_erase;
            col_q     <= col_addr;
            row_q     <= row_addr;
            len_q     <= byte_count;
            idx       <= '0;
            done      <= refuse;
            pass      <= 1'b0;
            refused   <= refuse;
            timed_out <= 1'b0;
            fail_blk  <= row_addr[ROW_W-1:BLK_SHIFT];
            if (refuse)                      st <= S_DONE;
            else if (use_spare && !op_erase) st <= S_PTR;
            else                             st <= S_CMD;
        end else begin
            case (st)
                S_PTR: if (eng_ack) st <= S_CMD;
                S_CMD: if (eng_ack) begin
                    st  <= S_ADDR;
                    idx <= '0;
                end
                S_ADDR: if (eng_ack) begin
                    idx <= (addr_sel == 2'd2) ? 9'd0 : idx + 9'd1;
                    if (addr_sel == 2'd2) st <= is_erase ? S_CONF : S_DATA;
                end
                S_DATA: if (eng_ack) begin
                    if (idx == len_q - 9'd1) st <= S_CONF;
                    else                     idx <= idx + 9'd1;
                end
                S_CONF: if (eng_ack) begin
                    st      <= S_GAP;
                    tmo_cnt <= '0;
                end
                S_GAP: begin
                    tmo_cnt <= tmo_cnt + 1'b1;
                    if (tmo_cnt == TMO_W'(WB_CYC - 1)) st <= S_WAIT;
                end
                S_WAIT: begin
                    if (nand_rb) begin
                        st <= S_STCMD;
                    end else if (tmo_cnt >= tmo_lim) begin
                        st        <= S_DONE;
                        done      <= 1'b1;
                        pass      <= 1'b0;
                        timed_out <= 1'b1;
                    end else begin
                        tmo_cnt <= tmo_cnt + 1'b1;
                    end
                end
                S_STCMD: if (eng_ack) st <= S_STRD;
                S_STRD: if (eng_ack) begin
                    ok_q <= ok_now;
                    if (is_spare) begin
                        st <= S_RESTORE;
                    end else begin
                        st   <= S_DONE;
                        done <= 1'b1;
                        pass <= ok_now;
                    end
                end
                S_RESTORE: if (eng_ack) begin
                    st   <= S_DONE;
                    done <= 1'b1;
                    pass <= ok_q;
                end
                default: ;
            endcase
        end
    end

    assign nand_ce_n = (st == S_IDLE) || (st == S_DONE);

    nand_bus_cycle #(
        .WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI)
    ) bus_i (
        .clk(clk), .rst_n(rst_n), .go(go), .req(breq),
        .ready(eng_ready), .ack(eng_ack), .rdat(eng_rdat),
        .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale),
        .dq_o(nand_dq_o), .dq_oe(nand_dq_oe), .dq_i(nand_dq_i)
    );

    nand_page_tally #(
        .ROW_W(ROW_W), .BLK_SHIFT(BLK_SHIFT), .LIMIT(PART_MAX)
    ) tally_i (
        .clk(clk), .rst_n(rst_n), .look_page(row_addr), .look_full(tally_full),
        .bump(bump), .wipe(wipe), .wipe_blk(row_q[ROW_W-1:BLK_SHIFT])
    );

    // R1: a deselected port has no strobe or latch activity.
    p_ce_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ce_n |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale));
    // R5: command and address qualifiers are exclusive.
    p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R6: no strobe while waiting out the busy period.
    p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_GAP) || (st == S_WAIT)) |-> (nand_we_n && nand_re_n));
    // R8: a timeout never reports success.
    p_timeout_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out |-> (done && !pass));
    // R9: a refused request leaves the device deselected.
    p_refuse_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        refused |-> nand_ce_n);
    // R12: result held while no new request arrives.
    p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(refused) && $stable(timed_out)));

endmodule

// File: tb/nand_pe_seq_tb.sv
`timescale 1ns/1ps
module nand_pe_seq_tb_top;
    localparam int ROW_W = 8, BLK_SHIFT = 4, BLK_W = ROW_W - BLK_SHIFT;
    localparam int WE_LO = 5, WE_HI = 5, RE_LO = 7, RE_HI = 3;
    localparam int WB_CYC = 30, PRG_TMO = 3000, ERS_TMO = 6000, PART_MAX = 10;
    localparam int RB_DLY = 10;
    localparam int LOGN = 300;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, start, op_erase, use_spare;
    logic [7:0] col_addr;
    logic [ROW_W-1:0] row_addr;
    logic [8:0] byte_count, buf_idx;
    logic [7:0] buf_data;
    logic done, pass, refused, timed_out;
    logic [BLK_W-1:0] fail_blk;
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_rb;
    logic [7:0] nand_dq_o, nand_dq_i;

    int total = 0, bad = 0;
    int cur_row = 0;

    function automatic logic [7:0] pat(int i, int r);
        return 8'((i * 13 + r * 3 + 33) & 255);
    endfunction

    assign buf_data = pat(int'(buf_idx), cur_row);

    // Device model state
    logic [10:0] log_q [LOGN];
    logic [10:0] exp_q [LOGN];
    int log_n = 0, exp_n = 0;
    int busy_cnt = 0, busy_len = 200;
    bit hung = 0, hang_mode = 0, early = 0;
    logic [7:0] stat_val = 8'hC0;
    int we_lo_run = 0, we_hi_run = 0, re_lo_run = 0, viol = 0;
    logic we_prev = 1'b1, re_prev = 1'b1;

    assign nand_rb   = !(hung || (busy_cnt > 0 && busy_cnt <= busy_len));
    assign nand_dq_i = (!nand_re_n && !nand_ce_n) ? stat_val : 8'h00;

    nand_pe_seq #(
        .ROW_W(ROW_W), .BLK_SHIFT(BLK_SHIFT), .WE_LO(WE_LO), .WE_HI(WE_HI),
        .RE_LO(RE_LO), .RE_HI(RE_HI), .WB_CYC(WB_CYC), .PRG_TMO(PRG_TMO),
        .ERS_TMO(ERS_TMO), .PART_MAX(PART_MAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
        .use_spare(use_spare), .col_addr(col_addr), .row_addr(row_addr),
        .byte_count(byte_count), .buf_idx(buf_idx), .buf_data(buf_data),
        .done(done), .pass(pass), .refused(refused), .timed_out(timed_out),
        .fail_blk(fail_blk), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
        .nand_rb(nand_rb)
    );

    // Device model: capture cycles, time strobes, drive ready/busy.
    always @(negedge clk) begin
        if (!nand_ce_n && !we_prev && nand_we_n) begin
            if (log_n < LOGN) log_q[log_n] = {1'b0, nand_cle, nand_ale, nand_dq_o};
            log_n++;
            if (!nand_dq_oe) viol++;
            if (nand_cle && nand_dq_o == 8'h70 && (busy_cnt > 0 || hung)) early = 1;
            if (nand_cle && (nand_dq_o == 8'h10 || nand_dq_o == 8'hD0)) begin
                if (hang_mode) hung = 1;
                else busy_cnt = RB_DLY + busy_len;
            end
        end else if (busy_cnt > 0) begin
            busy_cnt--;
        end
        if (!nand_ce_n && !re_prev && nand_re_n) begin
            if (log_n < LOGN) log_q[log_n] = 11'h400;
            log_n++;
        end
        if (!nand_we_n) begin
            if (we_prev && we_hi_run < WE_HI) viol++;
            we_lo_run++;
        end else begin
            if (!we_prev && we_lo_run != WE_LO) viol++;
            we_lo_run = 0;
        end
        if (nand_ce_n) we_hi_run = WE_HI;
        else if (nand_we_n) we_hi_run = we_prev ? we_hi_run + 1 : 1;
        else we_hi_run = 0;
        if (!nand_re_n) re_lo_run++;
        else begin
            if (!re_prev && re_lo_run != RE_LO) viol++;
            re_lo_run = 0;
        end
        we_prev = nand_we_n;
        re_prev = nand_re_n;
    end

    task automatic check(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic exp_push(logic [10:0] v);
        if (exp_n < LOGN) exp_q[exp_n] = v;
        exp_n++;
    endtask

    task automatic build_prog(bit spare, int col, int row, int len, bit tmo);
        exp_n = 0;
        if (spare) exp_push({3'b010, 8'h50});
        exp_push({3'b010, 8'h80});
        exp_push({3'b001, 8'(col)});
        exp_push({3'b001, 8'(row)});
        exp_push({3'b001, 8'h00});
        for (int i = 0; i < len; i++) exp_push({3'b000, pat(i, row)});
        exp_push({3'b010, 8'h10});
        if (!tmo) begin
            exp_push({3'b010, 8'h70});
            exp_push(11'h400);
            if (spare) exp_push({3'b010, 8'h00});
        end
    endtask

    task automatic build_erase(int row);
        exp_n = 0;
        exp_push({3'b010, 8'h60});
        exp_push({3'b001, 8'(row)});
        exp_push({3'b001, 8'h00});
        exp_push({3'b010, 8'hD0});
        exp_push({3'b010, 8'h70});
        exp_push(11'h400);
    endtask

    task automatic cmp_log(string req);
        int m = -1;
        check(log_n == exp_n, req, "cycle count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n && i < LOGN; i++)
            if (m < 0 && log_q[i] !== exp_q[i]) m = i;
        if (m >= 0) check(0, req, "cycle content", int'(log_q[m]), int'(exp_q[m]));
        else check(1, req, "cycle content", 0, 0);
    endtask

    task automatic run(bit er, bit sp, int col, int row, int len);
        int w = 0;
        @(negedge clk);
        op_erase = er; use_spare = sp; col_addr = 8'(col);
        row_addr = ROW_W'(row); byte_count = 9'(len); cur_row = row;
        log_n = 0; early = 0; viol = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        while (!done && w < 20000) begin @(negedge clk); w++; end
        check(w < 20000, "R12", "op finished", w, 0);
    endtask

    task automatic std_prog(string req, bit sp, int col, int row, int len);
        run(0, sp, col, row, len);
        build_prog(sp, col, row, len, 0);
        cmp_log(req);
        check(pass == 1'b1, "R7", "pass", int'(pass), 1);
        check(viol == 0, "R5", "strobe timing", viol, 0);
        check(!early, "R6", "status after busy", int'(early), 0);
        check(int'(fail_blk) == (row >> BLK_SHIFT), "R13", "fail_blk", int'(fail_blk), row >> BLK_SHIFT);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; start = 0; op_erase = 0; use_spare = 0;
        col_addr = 0; row_addr = 0; byte_count = 0;
        repeat (4) @(negedge clk);
        check(nand_ce_n && nand_we_n && nand_re_n, "R1", "strobes in reset", int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
        rst_n = 1;
        @(negedge clk);
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
              "R1", "idle port", int'({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}), 56);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);

        // R2: several lengths, columns and rows
        std_prog("R2", 0, 0, 8'h12, 1);
        std_prog("R2", 0, 0, 8'h25, 264);
        std_prog("R2", 0, 8'h80, 8'h3F, 7);
        // R3: spare wrapper
        std_prog("R3", 1, 3, 8'h40, 5);

        // R4: erase framing, spare flag ignored
        busy_len = 400;
        run(1, 1, 8'hAA, 8'h53, 9);
        build_erase(8'h53);
        cmp_log("R4");
        check(pass == 1'b1, "R4", "erase pass", int'(pass), 1);
        check(!early && viol == 0, "R6", "erase busy wait", int'(early) + viol, 0);
        busy_len = 200;

        // R7: failure bit set
        stat_val = 8'hC1;
        run(0, 0, 0, 8'h67, 3);
        build_prog(0, 0, 8'h67, 3, 0); cmp_log("R7");
        check(done && !pass, "R7", "fail status", int'(pass), 0);
        check(int'(fail_blk) == 6, "R13", "fail_blk on fail", int'(fail_blk), 6);
        // R7: not-ready status
        stat_val = 8'h80;
        run(0, 0, 0, 8'h68, 2);
        check(done && !pass, "R7", "not-ready status", int'(pass), 0);
        stat_val = 8'hC0;

        // R8: ready never returns
        hang_mode = 1;
        run(0, 0, 0, 8'h71, 4);
        build_prog(0, 0, 8'h71, 4, 1); cmp_log("R8");
        check(timed_out && !pass, "R8", "timeout flag", int'({timed_out, pass}), 2);
        check(int'(fail_blk) == 7, "R13", "fail_blk on timeout", int'(fail_blk), 7);
        hang_mode = 0; hung = 0;
        repeat (5) @(negedge clk);

        // R11: bad lengths
        run(0, 0, 0, 8'h72, 0);
        check(refused && !pass && log_n == 0, "R11", "zero length", log_n, 0);
        run(0, 0, 0, 8'h72, 265);
        check(refused && !pass && log_n == 0, "R11", "over length", log_n, 0);

        // R12: hold and ignored start
        repeat (40) @(negedge clk);
        check(done && refused && !pass && !timed_out, "R12", "held result", int'({done, refused, pass, timed_out}), 12);
        begin
            int w = 0;
            @(negedge clk);
            op_erase = 0; use_spare = 0; col_addr = 0; row_addr = 8'h81;
            byte_count = 2; cur_row = 8'h81; log_n = 0;
            start = 1; @(negedge clk); start = 0;
            repeat (30) @(negedge clk);
            op_erase = 1; row_addr = 8'h05; start = 1; @(negedge clk); start = 0;
            while (!done && w < 20000) begin @(negedge clk); w++; end
            build_prog(0, 0, 8'h81, 2, 0);
            cmp_log("R12");
        end

        // R9: eleventh partial program refused
        for (int k = 0; k < PART_MAX; k++) begin
            run(0, 0, k, 8'h90, 1);
            check(pass && !refused, "R9", "program within limit", k, k);
        end
        run(0, 0, 0, 8'h90, 1);
        check(refused && !pass && log_n == 0, "R9", "over limit", int'(refused), 1);
        std_prog("R9", 0, 0, 8'h91, 2);
        // R10: failing erase keeps counts
        stat_val = 8'hC1;
        run(1, 0, 0, 8'h9F, 1);
        stat_val = 8'hC0;
        run(0, 0, 0, 8'h90, 1);
        check(refused && log_n == 0, "R10", "failed erase keeps count", int'(refused), 1);
        // R10: passing erase clears block
        run(1, 0, 0, 8'h9F, 1);
        check(pass, "R10", "erase passes", int'(pass), 1);
        run(0, 0, 0, 8'h90, 1);
        check(pass && !refused, "R10", "count cleared", int'({pass, refused}), 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule